// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Bank

This block is the register bank of one core that receives inter-processor interrupts. It sits on a 32-bit register bus and holds three kinds of state: a 32-bit word of pending interrupt bits, a 32-bit enable word, and a small set of 32-bit mailbox words that other cores can use to pass data. It drives a single level-sensitive interrupt line to its core.

Software posts an interrupt by writing a bit mask to the set port. The mask is ORed into the pending word. Software acknowledges an interrupt by writing a mask to the clear port. The interrupt line is updated only by these two ports, and the rules for the two are not symmetric. A set raises the line when the new pending word ANDed with the enable word is non-zero. A clear drops the line only when the pending word becomes zero while the enable word is non-zero. In every other case the line keeps its previous level. This can leave the line stale, and the behaviour is kept on purpose. Writing the enable word never re-evaluates the line.

Only the low eight address bits take part in decoding, and address bits [1:0] are ignored because every access is a full 32-bit little-endian word. Reads are combinational and complete in the same cycle as `rd_i`.

Top module: `ipi_core_bank`

## Requirements
- R1: Only `addr_i[7:0]` is decoded. An access whose upper address bits differ, but whose low byte is the same, reaches the same register.
- R2: The pending word at offset 0x00 is read-only. A write there leaves every register and `irq_o` unchanged, and `wr_err_o` is high during that write cycle. `wr_err_o` is low in every other cycle.
- R3: A write to the set port at 0x08 ORs `wdata_i` into the pending word. If the new pending word ANDed with the enable word is non-zero, `irq_o` is 1 from the next cycle on.
- R4: A set write whose result ANDed with the enable word is zero leaves `irq_o` unchanged.
- R5: A write to the clear port at 0x0C removes the bits of `wdata_i` from the pending word. If the new pending word is zero and the enable word is non-zero, `irq_o` is 0 from the next cycle on.
- R6: A clear write whose result is non-zero, or one made while the enable word is zero, leaves `irq_o` unchanged.
- R7: Reads of the set and clear ports return zero.
- R8: The enable word at 0x04 is readable and writable. Writing it does not change `irq_o`.
- R9: Eight mailbox words sit at 0x20 + 4*k for k = 0..7. Each one reads back the last 32-bit value written to it.
- R10: Offsets 0x10 to 0x1C and 0x40 to 0xFC are unmapped. Reads there return zero, and writes there change no register and do not change `irq_o`.
- R11: After reset, the pending word, the enable word, every mailbox word and `irq_o` are all zero.
- R12: `rdata_o` shows the addressed register in the same cycle that `rd_i` is high, and it is zero while `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W (12) | Byte address; only bits [7:0] are decoded |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as `rd_i` |
| wr_err_o | output | 1 | High during a write to the read-only pending word |
| irq_o | output | 1 | Level interrupt to the core |

## Verification
Every cycle, the assertions check the edges of the interrupt line. A rise of `irq_o` must follow a set write, and a fall must follow a clear write made while the enable word was non-zero. They also check that a set which meets the enable word raises the line, that enable writes leave the line alone, that writes to the pending-word offset and to unmapped offsets change no state, and that a mailbox write lands in the selected word. Only the bench's scenarios can show that a stale level survives the enable word being zeroed or re-armed, because this depends on a chosen sequence of writes. The same holds for address aliasing of the upper bits and for the exact read value at each of the 64 word offsets.

// File: rtl/ipi_bank_pkg.sv
package ipi_bank_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned DEC_W  = 8;

  localparam logic [DEC_W-1:0] OFF_STAT = 8'h00;
  localparam logic [DEC_W-1:0] OFF_EN   = 8'h04;
  localparam logic [DEC_W-1:0] OFF_SET  = 8'h08;
  localparam logic [DEC_W-1:0] OFF_CLR  = 8'h0C;
  localparam logic [DEC_W-1:0] OFF_MBOX = 8'h20;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_EN,
    SEL_SET,
    SEL_CLR,
    SEL_MBOX
  } reg_sel_e;
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_bank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned MBOX_NUM = 8,
  localparam int unsigned IDX_W   = (MBOX_NUM > 1) ? $clog2(MBOX_NUM) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned MBOX_END = int'(OFF_MBOX) + 4 * MBOX_NUM;

  logic [DEC_W-1:0] off;
  logic [DEC_W-3:0] word;
  logic [DEC_W-1:0] mbox_rel;
  logic             in_mbox;

  assign off      = {addr_i[DEC_W-1:2], 2'b00};
  assign word     = off[DEC_W-1:2];
  assign mbox_rel = off - OFF_MBOX;
  assign in_mbox  = ({1'b0, off} >= {1'b0, OFF_MBOX}) &&
                    ({1'b0, off} <  (DEC_W+1)'(MBOX_END));

  always_comb begin
    sel_o = SEL_NONE;
    idx_o = '0;
    if (word == OFF_STAT[DEC_W-1:2])      sel_o = SEL_STAT;
    else if (word == OFF_EN[DEC_W-1:2])   sel_o = SEL_EN;
    else if (word == OFF_SET[DEC_W-1:2])  sel_o = SEL_SET;
    else if (word == OFF_CLR[DEC_W-1:2])  sel_o = SEL_CLR;
    else if (in_mbox) begin
      sel_o = SEL_MBOX;
      idx_o = mbox_rel[IDX_W+1:2];
    end
  end
endmodule

// File: rtl/ipi_status_ctrl.sv
module ipi_status_ctrl
  import ipi_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_wr_i,
  input  logic              clr_wr_i,
  input  logic              en_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] en_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] status_q, en_q, set_nxt, clr_nxt;
  logic              irq_q;

  assign set_nxt = status_q | wdata_i;
  assign clr_nxt = status_q & ~wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      en_q     <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (en_wr_i) en_q <= wdata_i;
      if (set_wr_i) begin
        status_q <= set_nxt;
        if ((set_nxt & en_q) != '0) irq_q <= 1'b1;
      end
      if (clr_wr_i) begin
        status_q <= clr_nxt;
        // drop only on empty status with a non-zero enable
        if (clr_nxt == '0 && en_q != '0) irq_q <= 1'b0;
      end
    end
  end

  assign status_o = status_q;
  assign en_o     = en_q;
  assign irq_o    = irq_q;

  assert_irq_rise_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(set_wr_i));
  assert_set_raises_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_wr_i && ((status_q | wdata_i) & en_q) != '0) |=> irq_q);
  assert_irq_fall_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_q) |-> ($past(clr_wr_i) && $past(en_q) != '0));
  assert_en_keeps_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr_i |=> $stable(irq_q));
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_bank_pkg::*;
#(
  parameter int unsigned MBOX_NUM = 8,
  localparam int unsigned IDX_W   = (MBOX_NUM > 1) ? $clog2(MBOX_NUM) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] word_q [MBOX_NUM];

  for (genvar k = 0; k < MBOX_NUM; k++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             word_q[k] <= '0;
      else if (wr_i && idx_i == IDX_W'(k))     word_q[k] <= wdata_i;
    end

    assert_mbox_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && idx_i == IDX_W'(k)) |=> (word_q[k] == $past(wdata_i)));
  end

  assign rdata_o = word_q[idx_i];
endmodule

// File: rtl/ipi_core_bank.sv
module ipi_core_bank
  import ipi_bank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned MBOX_NUM = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              wr_err_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W = (MBOX_NUM > 1) ? $clog2(MBOX_NUM) : 1;

  reg_sel_e          sel;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] status, en, mbox_rd;
  logic [DATA_W-1:0] rd_mux;

  ipi_addr_decode #(.ADDR_W(ADDR_W), .MBOX_NUM(MBOX_NUM)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel),
    .idx_o  (idx)
  );

  ipi_status_ctrl u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_wr_i (wr_i && sel == SEL_SET),
    .clr_wr_i (wr_i && sel == SEL_CLR),
    .en_wr_i  (wr_i && sel == SEL_EN),
    .wdata_i  (wdata_i),
    .status_o (status),
    .en_o     (en),
    .irq_o    (irq_o)
  );

  ipi_mailbox #(.MBOX_NUM(MBOX_NUM)) u_mbox (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i && sel == SEL_MBOX),
    .idx_i   (idx),
    .wdata_i (wdata_i),
    .rdata_o (mbox_rd)
  );

  always_comb begin
    unique case (sel)
      SEL_STAT: rd_mux = status;
      SEL_EN:   rd_mux = en;
      SEL_MBOX: rd_mux = mbox_rd;
      default:  rd_mux = '0;
    endcase
  end

  assign rdata_o  = rd_i ? rd_mux : '0;
  assign wr_err_o = wr_i && sel == SEL_STAT;

  assert_stat_wr_inert_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |=> ($stable(status) && $stable(en) && $stable(irq_o)));
  assert_unmapped_wr_inert_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel == SEL_NONE) |=> ($stable(status) && $stable(en) && $stable(irq_o)));
  assert_idle_rdata_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);
endmodule

// File: tb/ipi_core_bank_tb.sv
module ipi_core_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        wr_err, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_stat, m_en;
  logic [31:0] m_mb [8];
  logic        m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_core_bank #(.ADDR_W(AW), .MBOX_NUM(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .wr_err_o(wr_err), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [7:0] off);
    logic [7:0] w = {off[7:2], 2'b00};
    if (w == 8'h00) return m_stat;
    if (w == 8'h04) return m_en;
    if (w >= 8'h20 && w < 8'h40) return m_mb[(w - 8'h20) >> 2];
    return 32'h0;
  endfunction

  task automatic do_wr(logic [7:0] off, logic [31:0] d, logic [3:0] hi = 4'h0);
    logic [7:0] w = {off[7:2], 2'b00};
    logic [31:0] nx;
    @(negedge clk);
    wr = 1'b1; addr = {hi, off}; wdata = d;
    #1 chk("R2 err flag", 32'(wr_err), 32'(w == 8'h00));
    @(posedge clk); #1 wr = 1'b0;
    if (w == 8'h04) m_en = d;
    else if (w == 8'h08) begin
      m_stat = m_stat | d;
      if ((m_stat & m_en) != 0) m_irq = 1'b1;
    end else if (w == 8'h0C) begin
      m_stat = m_stat & ~d;
      if (m_stat == 0 && m_en != 0) m_irq = 1'b0;
    end else if (w >= 8'h20 && w < 8'h40) m_mb[(w - 8'h20) >> 2] = d;
    nx = 32'(m_irq);
    @(negedge clk);
    chk("R3/R4/R5/R6/R8 irq level", 32'(irq), nx);
    chk("R2 err idle", 32'(wr_err), 32'h0);
  endtask

  task automatic do_rd(string req, logic [7:0] off, logic [3:0] hi = 4'h0);
    @(negedge clk);
    rd = 1'b1; addr = {hi, off};
    #1 chk(req, rdata, exp_rd(off));
    rd = 1'b0;
    #1 chk("R12 idle rdata", rdata, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_stat = 0; m_en = 0; m_irq = 0;
    for (int k = 0; k < 8; k++) m_mb[k] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state, every word offset
    @(negedge clk);
    chk("R11 irq after reset", 32'(irq), 32'h0);
    for (int o = 0; o < 64; o++) do_rd("R11 reset read", 8'(o * 4));

    // R3 R4 R5 R6 R7 R8 per-bit sweep
    for (int i = 0; i < 32; i++) begin
      logic [31:0] bi = 32'h1 << i;
      logic [31:0] bj = 32'h1 << ((i + 1) % 32);
      do_wr(8'h04, 32'h0);
      do_wr(8'h08, bi);                       // R4 enable zero
      do_rd("R3 status or", 8'h00);
      do_wr(8'h04, bi);                       // R8 no re-evaluation
      chk("R8 stale low", 32'(irq), 32'h0);
      do_rd("R8 enable readback", 8'h04);
      do_wr(8'h08, bi);                       // R3 raise
      chk("R3 raised", 32'(irq), 32'h1);
      do_wr(8'h08, bj);
      do_rd("R3 status accumulate", 8'h00);
      do_rd("R7 set reads zero", 8'h08);
      do_rd("R7 clear reads zero", 8'h0C);
      do_wr(8'h0C, bi);                       // R6 residue keeps level
      chk("R6 residue holds", 32'(irq), 32'h1);
      do_wr(8'h04, 32'h0);
      do_wr(8'h0C, bj);                       // R6 enable zero keeps level
      chk("R6 stale high", 32'(irq), 32'h1);
      do_rd("R5 status empty", 8'h00);
      do_wr(8'h04, ~bi);
      do_wr(8'h0C, 32'h0);                    // R5 drop
      chk("R5 dropped", 32'(irq), 32'h0);
    end

    // R2 status write ignored, with irq high
    do_wr(8'h04, 32'hFFFF_FFFF);
    do_wr(8'h08, 32'h0000_00F0);
    do_wr(8'h00, 32'hFFFF_FFFF);
    do_wr(8'h02, 32'h0);
    do_rd("R2 status unchanged", 8'h00);

    // R9 R1 mailbox with aliased upper bits and byte offsets
    for (int k = 0; k < 8; k++)
      do_wr(8'(8'h20 + k * 4 + (k % 4)), 32'hA5A5_0000 ^ (32'(k) * 32'h0101_1111), 4'(k + 1));
    for (int k = 0; k < 8; k++) begin
      do_rd("R9 mailbox readback", 8'(8'h20 + k * 4));
      do_rd("R1 aliased read", 8'(8'h20 + k * 4), 4'hF - 4'(k));
    end

    // R10 unmapped writes and reads
    for (int o = 4; o < 8; o++) do_wr(8'(o * 4), 32'hDEAD_BEEF);
    for (int o = 16; o < 64; o += 3) do_wr(8'(o * 4), 32'hFFFF_FFFF, 4'h3);
    chk("R10 irq kept", 32'(irq), 32'(m_irq));
    for (int o = 0; o < 64; o++) do_rd("R10 full map", 8'(o * 4), 4'h5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule